// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a software-controlled interval timer for a small register bus. Software programs a 32-bit period through two 16-bit registers, chooses between one-shot and repeating operation, and starts or stops the count with write events to the control register. While the timer runs, the counter drops by one on each clock. When a running counter sits at zero, the next clock edge reloads it from the period and raises a sticky timeout flag. The flag stays up until software writes the status register.

The timeout flag and an interrupt-enable bit together drive a level interrupt. A repeating timer keeps counting after each reload. A one-shot timer stops after its reload, so a later start begins again from the reloaded period. A start given to a stopped timer resumes from whatever value the counter holds. A build-time parameter can remove software stop control.

Top module: `ivtimer`

## Requirements
- R1: After reset the status and control registers read 0, the period registers read the RESET_PERIOD parameter (low half at address 2, high half at address 3), the timer is stopped and the interrupt output is low.
- R2: Registers are decoded from the 2-bit address: 0 is status (bit 0 timeout flag, bit 1 running), 1 is control (bit 0 interrupt enable, bit 1 repeat mode, bit 2 start event, bit 3 stop event; bits 2 and 3 read as 0), 2 is the period low half and 3 is the period high half. Reads are combinational.
- R3: While the timer runs, the counter decrements on each clock. If a start is written with the counter at value C, the timeout flag becomes 1 on the C+1-th clock edge after the start write edge, and on that edge the counter reloads from the period.
- R4: The timeout flag stays 1 until any write to address 0 clears it. A timeout on the same edge as that write leaves the flag at 1.
- R5: The running bit (status bit 1) is never changed by a write to the status register, whatever value is written.
- R6: The interrupt output is high exactly when the interrupt enable bit and the timeout flag are both 1.
- R7: With the repeat bit at 1 the timer keeps running after a reload. With it at 0 the timer stops on the reload edge.
- R8: Writing control with bit 2 set starts a stopped timer from the counter's current value. The same write to a running timer does not disturb its count.
- R9: Writing control with bit 3 set stops a running timer and holds the count. When bits 2 and 3 are written together, the stop wins.
- R10: A write to either period register updates that half of the period, loads the counter with the whole new period and stops the timer.
- R11: With RUN_CTL set to 0, the stop bit is ignored and a running timer keeps counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the addressed register |
| irq | output | 1 | Level interrupt |

## Verification
Two situations are hardest to create from the ports. The first is a timeout that lands on the same edge as a status write. The bench reaches it by counting edges from a start write with a short period, so that the clear lands exactly on the reload edge. The second is telling a resume from the held count apart from a restart from the period, since the counter cannot be read. The bench stops the timer partway through a long period, restarts it, and checks that the timeout arrives on the edge that the remaining count predicts, one edge before and on the expected edge.

// File: rtl/ivtimer.sv
module ivtimer #(
  parameter int DW = 16,
  parameter logic [2*DW-1:0] RESET_PERIOD = 32'd49999,
  parameter bit RUN_CTL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] cnt, per_q, per_nx;
  logic run_q, to_q, ien_q, cont_q;

  wire wr_stat = wr_en && addr == 2'd0;
  wire wr_ctl  = wr_en && addr == 2'd1;
  wire wr_plo  = wr_en && addr == 2'd2;
  wire wr_phi  = wr_en && addr == 2'd3;
  wire go      = wr_ctl && wdata[2];
  wire halt    = RUN_CTL && wr_ctl && wdata[3];
  wire hit     = run_q && cnt == '0;

  assign per_nx = {wr_phi ? wdata : per_q[PW-1:DW], wr_plo ? wdata : per_q[DW-1:0]};
  assign irq = ien_q & to_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= RESET_PERIOD;
      per_q  <= RESET_PERIOD;
      run_q  <= 1'b0;
      to_q   <= 1'b0;
      ien_q  <= 1'b0;
      cont_q <= 1'b0;
    end else begin
      if (wr_plo || wr_phi) begin
        per_q <= per_nx;
        cnt   <= per_nx;
        run_q <= 1'b0;
      end else if (hit) begin
        cnt   <= per_q;
        run_q <= cont_q && !halt;
      end else if (halt) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        cnt <= cnt - 1'b1;
      end else if (go) begin
        run_q <= 1'b1;
      end

      if (hit) to_q <= 1'b1;
      else if (wr_stat) to_q <= 1'b0;

      if (wr_ctl) {cont_q, ien_q} <= wdata[1:0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      2'd0: rdata[1:0] = {run_q, to_q};
      2'd1: rdata[1:0] = {cont_q, ien_q};
      2'd2: rdata = per_q[DW-1:0];
      2'd3: rdata = per_q[PW-1:DW];
    endcase
  end
endmodule

// File: rtl/ivtimer_chk.sv
module ivtimer_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      addr,
  input logic            wr_en,
  input logic [1:0]      ev,
  input logic            running,
  input logic            tflag,
  input logic            cont,
  input logic [2*DW-1:0] count,
  input logic [2*DW-1:0] period
);
  wire at_zero = running && count == '0;
  wire bus_wr  = wr_en && addr != 2'd0;

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    at_zero |=> tflag);

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    running && count != '0 && !bus_wr |=> count == $past(count) - 1'b1);

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tflag && !(wr_en && addr == 2'd0) |=> tflag);

  assert_run_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd0 && !at_zero |=> running == $past(running));

  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    at_zero && !cont |=> !running);

  assert_start_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !running && wr_en && addr == 2'd1 && ev == 2'b01 |=> running && $stable(count));

  assert_period_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr[1] |=> !running && count == period);
endmodule

bind ivtimer ivtimer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .ev(wdata[3:2]),
  .running(run_q), .tflag(to_q), .cont(cont_q), .count(cnt), .period(per_q)
);

// File: tb/test_ivtimer.sv
`timescale 1ns/100ps
module test_ivtimer;
  localparam logic [31:0] RP = 32'h0003_0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0, wr_en2 = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, rdata2;
  logic irq, irq2;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ivtimer #(.DW(16), .RESET_PERIOD(RP)) i_ivtimer (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  ivtimer #(.DW(16), .RESET_PERIOD(RP), .RUN_CTL(1'b0)) i_ivtimer_nostop (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en2),
    .wdata(wdata), .rdata(rdata2), .irq(irq2));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr2(logic [1:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en2 = 1'b1;
    @(negedge clk);
    wr_en2 = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d, output logic [15:0] d2);
    addr = a;
    #0.5;
    d = rdata; d2 = rdata2;
  endtask

  task automatic stat(string tag, logic to, logic run);
    logic [15:0] d, d2;
    rd(2'd0, d, d2);
    check(tag, {30'd0, d[1:0]}, {30'd0, run, to});
  endtask

  task automatic stat2(string tag, logic to, logic run);
    logic [15:0] d, d2;
    rd(2'd0, d, d2);
    check(tag, {30'd0, d2[1:0]}, {30'd0, run, to});
  endtask

  task automatic set_period(logic [31:0] p);
    wr(2'd2, p[15:0]);
    wr(2'd3, p[31:16]);
  endtask

  task automatic t_reset;
    logic [15:0] d, d2;
    stat("R1 status after reset", 1'b0, 1'b0);
    rd(2'd1, d, d2); check("R1 control after reset", {16'd0, d}, 32'd0);
    rd(2'd2, d, d2); check("R1 R2 period low after reset", {16'd0, d}, {16'd0, RP[15:0]});
    rd(2'd3, d, d2); check("R1 R2 period high after reset", {16'd0, d}, {16'd0, RP[31:16]});
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_oneshot;
    set_period(32'd5);
    wr(2'd1, 16'h0005);
    stat("R8 started", 1'b0, 1'b1);
    idle(5);
    stat("R3 one edge before timeout", 1'b0, 1'b1);
    check("R6 irq low before timeout", {31'd0, irq}, 32'd0);
    idle(1);
    stat("R3 R7 one-shot timeout and stop", 1'b1, 1'b0);
    check("R6 irq with enable and flag", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_sticky;
    idle(7);
    stat("R4 flag stays set", 1'b1, 1'b0);
    wr(2'd0, 16'h0002);
    stat("R4 R5 status write clears flag, run untouched", 1'b0, 1'b0);
    check("R6 irq after clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_repeat;
    wr(2'd1, 16'h0000);
    set_period(32'd3);
    wr(2'd1, 16'h0006);
    idle(3);
    stat("R3 repeat before first timeout", 1'b0, 1'b1);
    idle(1);
    stat("R7 repeat keeps running at timeout", 1'b1, 1'b1);
    check("R6 irq gated by enable", {31'd0, irq}, 32'd0);
    wr(2'd0, 16'h0000);
    stat("R5 status write leaves run bit", 1'b0, 1'b1);
    idle(2);
    stat("R3 reload count before second timeout", 1'b0, 1'b1);
    idle(1);
    stat("R7 second timeout after reload", 1'b1, 1'b1);
  endtask

  task automatic t_stop;
    wr(2'd1, 16'h000A);
    stat("R9 stop halts timer", 1'b1, 1'b0);
    wr(2'd0, 16'h0000);
    idle(10);
    stat("R9 stopped timer stays quiet", 1'b0, 1'b0);
  endtask

  task automatic t_resume;
    set_period(32'd10);
    wr(2'd1, 16'h0004);
    idle(3);
    wr(2'd1, 16'h0008);
    stat("R9 stop mid count", 1'b0, 1'b0);
    wr(2'd1, 16'h0004);
    idle(7);
    stat("R8 resume, one edge before timeout", 1'b0, 1'b1);
    idle(1);
    stat("R8 resume from held count", 1'b1, 1'b0);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_start_running;
    set_period(32'd6);
    wr(2'd1, 16'h0004);
    idle(2);
    wr(2'd1, 16'h0004);
    idle(3);
    stat("R8 restart ignored, before timeout", 1'b0, 1'b1);
    idle(1);
    stat("R8 restart ignored, timeout on time", 1'b1, 1'b0);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_both;
    wr(2'd1, 16'h000C);
    stat("R9 start with stop on stopped timer", 1'b0, 1'b0);
    wr(2'd1, 16'h0004);
    wr(2'd1, 16'h000C);
    stat("R9 start with stop on running timer", 1'b0, 1'b0);
  endtask

  task automatic t_period_stop;
    logic [15:0] d, d2;
    set_period(32'd100);
    wr(2'd1, 16'h0006);
    stat("R10 running before period write", 1'b0, 1'b1);
    wr(2'd2, 16'd50);
    stat("R10 period write stops timer", 1'b0, 1'b0);
    rd(2'd2, d, d2); check("R2 R10 period low readback", {16'd0, d}, 32'd50);
    rd(2'd3, d, d2); check("R2 R10 period high readback", {16'd0, d}, 32'd0);
    wr(2'd1, 16'h0004);
    idle(50);
    stat("R10 loaded count, before timeout", 1'b0, 1'b1);
    idle(1);
    stat("R10 loaded count, timeout", 1'b1, 1'b0);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_priority;
    set_period(32'd2);
    wr(2'd1, 16'h0004);
    idle(2);
    wr(2'd0, 16'h0000);
    stat("R4 timeout wins over same-edge clear", 1'b1, 1'b0);
  endtask

  task automatic t_irq;
    wr(2'd1, 16'h0000);
    check("R6 irq low with enable off", {31'd0, irq}, 32'd0);
    wr(2'd1, 16'h0001);
    check("R6 irq high when enable set", {31'd0, irq}, 32'd1);
    wr(2'd0, 16'h0000);
    check("R6 irq low after clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_nostop;
    wr2(2'd2, 16'd20);
    wr2(2'd3, 16'd0);
    wr2(2'd1, 16'h0004);
    wr2(2'd1, 16'h0008);
    stat2("R11 stop ignored without run control", 1'b0, 1'b1);
    idle(25);
    stat2("R11 one-shot still ends", 1'b1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_oneshot();
    t_sticky();
    t_repeat();
    t_stop();
    t_resume();
    t_start_running();
    t_both();
    t_period_stop();
    t_priority();
    t_irq();
    t_nostop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule